// File: doc/BRIEF.md
# UART Register Front End

This block is the bus-facing half of a simple serial port. A 32-bit memory-mapped bus reaches seven word registers. Bytes from the line side arrive on a valid/ready byte stream and wait in an eight-entry receive queue. Software drains the queue by reading the receive data register, and each such read removes the byte it returns. A word written to the transmit data register leaves on an outgoing byte stream as a one-cycle pulse that carries its low byte. The bit shifter and the baud generator that would use the divisor value belong to another block.

Two control registers each hold a three-bit watermark count. The pending register is read-only and is rebuilt every cycle from those counts and the queue fill level. One level interrupt output is raised whenever an enabled pending bit is set. The outgoing stream is driven by a two-state machine. `TX_IDLE` moves to `TX_SEND` on a transmit-data write. `TX_SEND` stays in `TX_SEND` on another write and returns to `TX_IDLE` otherwise. `tx_valid` is high only in `TX_SEND`.

Top module: `uart_regfile`

## Requirements
- R1: After reset all writable registers read 0, the receive queue is empty, `rx_ready` is 1, and `tx_valid` and `irq` are 0.
- R2: A full-word read of offset 0x04 while the queue holds data returns the oldest byte in bits [7:0] with bit 31 clear, and removes that byte at the end of the access cycle. Bytes come out in arrival order.
- R3: A full-word read of offset 0x04 while the queue is empty returns 0x80000000 and changes no state.
- R4: A full-word write to offset 0x00 gives `tx_valid` high for the following cycle, with `tx_data` equal to bits [7:0] of the written word. A read of offset 0x00 returns 0.
- R5: Transmit control (0x08), receive control (0x0C), interrupt enable (0x10) and divisor (0x18) read back the last full-word value written to them.
- R6: Pending bit 1 at offset 0x14 is 1 exactly while the queue fill level is strictly greater than bits [18:16] of receive control.
- R7: Pending bit 0 at offset 0x14 is 1 exactly while bits [18:16] of transmit control are nonzero.
- R8: The queue holds 8 bytes. `rx_ready` is 0 while it is full, and a byte offered while it is full is discarded.
- R9: `irq` is the OR over bits 1:0 of (enable AND pending), where bit 0 is the transmit watermark and bit 1 the receive watermark.
- R10: An access whose byte enables are not all four set has no side effect and reads as 0.
- R11: Offsets that are not mapped read as 0, and writes to them are ignored.
- R12: Writes to the pending register at 0x14 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 5 | Byte offset of the register |
| bus_be | input | 4 | Byte enables; only 4'hF has side effects |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the access cycle |
| rx_valid | input | 1 | Incoming byte present |
| rx_data | input | 8 | Incoming byte |
| rx_ready | output | 1 | Queue can take a byte |
| tx_valid | output | 1 | Outgoing byte pulse |
| tx_data | output | 8 | Outgoing byte |
| irq | output | 1 | Level interrupt |

## Verification
The queue is exercised with a fill level below, at and above the receive watermark. It is also driven to full with two extra bytes offered, which separates a strict greater-than compare from greater-or-equal and shows whether overflow bytes are dropped or overwrite stored ones. Reads of an empty queue, narrow reads of a non-empty queue and writes to the pending and unmapped offsets confirm that these accesses leave state untouched. The interrupt is checked with each enable bit alone against each pending source alone, so that a swapped bit mapping shows up.

// File: rtl/uart_rf_pkg.sv
package uart_rf_pkg;
    localparam int ADDR_W = 5;

    localparam logic [ADDR_W-1:0] OFS_TXDATA = 5'h00;
    localparam logic [ADDR_W-1:0] OFS_RXDATA = 5'h04;
    localparam logic [ADDR_W-1:0] OFS_TXCTRL = 5'h08;
    localparam logic [ADDR_W-1:0] OFS_RXCTRL = 5'h0C;
    localparam logic [ADDR_W-1:0] OFS_IE     = 5'h10;
    localparam logic [ADDR_W-1:0] OFS_IP     = 5'h14;
    localparam logic [ADDR_W-1:0] OFS_DIV    = 5'h18;

    localparam int IRQ_TXWM = 0;
    localparam int IRQ_RXWM = 1;

    typedef enum logic {
        TX_IDLE = 1'b0,
        TX_SEND = 1'b1
    } tx_state_e;
endpackage

// File: rtl/uart_rx_queue.sv
module uart_rx_queue #(
    parameter int DEPTH = 8,
    parameter int DW    = 8,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [DW-1:0]    din,
    input  logic             pop,
    output logic [DW-1:0]    dout,
    output logic [CNT_W-1:0] count,
    output logic             full,
    output logic             empty
);
    logic [DW-1:0]    mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic             do_push, do_pop;

    assign full    = (count == CNT_W'(DEPTH));
    assign empty   = (count == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign dout    = mem[rd_ptr];

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) wr_ptr <= bump(wr_ptr);
            if (do_pop)  rd_ptr <= bump(rd_ptr);
            case ({do_push, do_pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= din;
    end

    // R8
    fill_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CNT_W'(DEPTH));

    // R8
    full_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (full && push && !pop) |=> full);

    // R3
    empty_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (empty && pop && !push) |=> empty);
endmodule

// File: rtl/uart_tx_emit.sv
module uart_tx_emit
    import uart_rf_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          send,
    input  logic [DW-1:0] byte_in,
    output logic          tx_valid,
    output logic [DW-1:0] tx_data
);
    tx_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= TX_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)    tx_data <= '0;
        else if (send) tx_data <= byte_in;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TX_IDLE: state_d = send ? TX_SEND : TX_IDLE;
            TX_SEND: state_d = send ? TX_SEND : TX_IDLE;
        endcase
    end

    always_comb begin
        tx_valid = (state_q == TX_SEND);
    end

    // R4
    tx_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        send |=> (tx_valid && tx_data == $past(byte_in)));

    // R4
    tx_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !send |=> !tx_valid);
endmodule

// File: rtl/uart_regfile.sv
module uart_regfile
    import uart_rf_pkg::*;
#(
    parameter int DEPTH  = 8,
    parameter int WM_LSB = 16,
    parameter int WM_W   = 3,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [3:0]        bus_be,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic              rx_valid,
    input  logic [7:0]        rx_data,
    output logic              rx_ready,
    output logic              tx_valid,
    output logic [7:0]        tx_data,
    output logic              irq
);
    logic [31:0]      txctrl_q, rxctrl_q, ie_q, div_q;
    logic             full_acc, wr_acc, rd_acc;
    logic             q_pop, q_full, q_empty;
    logic [7:0]       q_dout;
    logic [CNT_W-1:0] q_count;
    logic [1:0]       pend;
    logic [WM_W-1:0]  tx_wm, rx_wm;

    assign full_acc = bus_sel && (bus_be == 4'hF);
    assign wr_acc   = full_acc && bus_wr;
    assign rd_acc   = full_acc && !bus_wr;
    assign q_pop    = rd_acc && (bus_addr == OFS_RXDATA);
    assign rx_ready = !q_full;

    uart_rx_queue #(.DEPTH(DEPTH), .DW(8)) u_rxq (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (rx_valid),
        .din   (rx_data),
        .pop   (q_pop),
        .dout  (q_dout),
        .count (q_count),
        .full  (q_full),
        .empty (q_empty)
    );

    uart_tx_emit #(.DW(8)) u_txe (
        .clk      (clk),
        .rst_n    (rst_n),
        .send     (wr_acc && (bus_addr == OFS_TXDATA)),
        .byte_in  (bus_wdata[7:0]),
        .tx_valid (tx_valid),
        .tx_data  (tx_data)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            txctrl_q <= '0;
            rxctrl_q <= '0;
            ie_q     <= '0;
            div_q    <= '0;
        end else if (wr_acc) begin
            case (bus_addr)
                OFS_TXCTRL: txctrl_q <= bus_wdata;
                OFS_RXCTRL: rxctrl_q <= bus_wdata;
                OFS_IE:     ie_q     <= bus_wdata;
                OFS_DIV:    div_q    <= bus_wdata;
                default:    ;
            endcase
        end
    end

    assign tx_wm = txctrl_q[WM_LSB +: WM_W];
    assign rx_wm = rxctrl_q[WM_LSB +: WM_W];

    always_comb begin
        pend           = '0;
        pend[IRQ_TXWM] = (tx_wm != '0);
        pend[IRQ_RXWM] = (32'(q_count) > 32'(rx_wm));
    end

    assign irq = |(ie_q[1:0] & pend);

    always_comb begin
        bus_rdata = '0;
        if (rd_acc) begin
            case (bus_addr)
                OFS_RXDATA: bus_rdata = q_empty ? 32'h8000_0000 : {24'h0, q_dout};
                OFS_TXCTRL: bus_rdata = txctrl_q;
                OFS_RXCTRL: bus_rdata = rxctrl_q;
                OFS_IE:     bus_rdata = ie_q;
                OFS_IP:     bus_rdata = {30'h0, pend};
                OFS_DIV:    bus_rdata = div_q;
                default:    bus_rdata = '0;
            endcase
        end
    end

    // R2
    pop_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q_pop && !q_empty && !rx_valid) |=> (q_count == $past(q_count) - 1'b1));

    // R3
    empty_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q_pop && q_empty && !rx_valid) |=> $stable(q_count));

    // R10
    narrow_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_be != 4'hF) |=> ($stable(ie_q) && $stable(txctrl_q) &&
                                        $stable(rxctrl_q) && $stable(div_q)));

    // R9
    tx_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ie_q[IRQ_TXWM] && txctrl_q[WM_LSB +: WM_W] != '0) |-> irq);

    // R9
    quiet_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ie_q[1:0] == 2'b00) |-> !irq);
endmodule

// File: tb/sim_uart_regfile.sv
module sim_uart_regfile;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0, bus_wr = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [3:0]  bus_be = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        rx_valid = 1'b0;
    logic [7:0]  rx_data = '0;
    logic        rx_ready, tx_valid, irq;
    logic [7:0]  tx_data;

    int checks = 0;
    int failures = 0;

    always #4 clk = ~clk;

    uart_regfile u0 (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_be(bus_be), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .rx_valid(rx_valid), .rx_data(rx_data),
        .rx_ready(rx_ready), .tx_valid(tx_valid), .tx_data(tx_data), .irq(irq)
    );

    // Vector fields: [74:71] requirement, [70:69] op, [68:64] offset,
    // [63:32] write data or pushed byte, [31:0] expected read data.
    localparam logic [1:0] OP_W = 2'd0, OP_R = 2'd1, OP_P = 2'd2;
    localparam int NV = 23;
    localparam logic [74:0] VEC [NV] = '{
        {4'd7,  OP_R, 5'h14, 32'h0,          32'h0},          // R7 nothing pending
        {4'd5,  OP_W, 5'h08, 32'h0003_0000,  32'h0},          // R5
        {4'd5,  OP_R, 5'h08, 32'h0,          32'h0003_0000},  // R5
        {4'd7,  OP_R, 5'h14, 32'h0,          32'h1},          // R7 tx wm nonzero
        {4'd5,  OP_W, 5'h0C, 32'h0001_0000,  32'h0},          // R5
        {4'd5,  OP_R, 5'h0C, 32'h0,          32'h0001_0000},  // R5
        {4'd5,  OP_W, 5'h18, 32'h0000_01B2,  32'h0},          // R5
        {4'd5,  OP_R, 5'h18, 32'h0,          32'h0000_01B2},  // R5
        {4'd5,  OP_W, 5'h10, 32'h3,          32'h0},          // R5
        {4'd5,  OP_R, 5'h10, 32'h0,          32'h3},          // R5
        {4'd2,  OP_P, 5'h00, 32'h11,         32'h0},          // R2
        {4'd6,  OP_R, 5'h14, 32'h0,          32'h1},          // R6 level 1 not above 1
        {4'd2,  OP_P, 5'h00, 32'h22,         32'h0},          // R2
        {4'd6,  OP_R, 5'h14, 32'h0,          32'h3},          // R6 level 2 above 1
        {4'd2,  OP_R, 5'h04, 32'h0,          32'h11},         // R2 oldest first
        {4'd6,  OP_R, 5'h14, 32'h0,          32'h1},          // R6
        {4'd2,  OP_R, 5'h04, 32'h0,          32'h22},         // R2
        {4'd3,  OP_R, 5'h04, 32'h0,          32'h8000_0000},  // R3
        {4'd4,  OP_R, 5'h00, 32'h0,          32'h0},          // R4
        {4'd12, OP_W, 5'h14, 32'hFFFF_FFFF,  32'h0},          // R12
        {4'd12, OP_R, 5'h14, 32'h0,          32'h1},          // R12
        {4'd11, OP_W, 5'h1C, 32'h0000_FFFF,  32'h0},          // R11
        {4'd11, OP_R, 5'h1C, 32'h0,          32'h0}           // R11
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [3:0] be, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_be = be; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0; bus_be = '0; bus_wdata = '0;
    endtask

    task automatic rd(input logic [4:0] a, input logic [3:0] be, output logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a; bus_be = be;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_sel = 1'b0; bus_be = '0;
    endtask

    task automatic push(input logic [7:0] b);
        @(negedge clk);
        rx_valid = 1'b1; rx_data = b;
        @(negedge clk);
        rx_valid = 1'b0;
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [31:0] d;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1 rx_ready", 32'(rx_ready), 32'h1);
        chk("R1 irq", 32'(irq), 32'h0);
        chk("R1 tx_valid", 32'(tx_valid), 32'h0);
        rd(5'h10, 4'hF, d); chk("R1 enable", d, 32'h0);
        rd(5'h08, 4'hF, d); chk("R1 txctrl", d, 32'h0);
        rd(5'h04, 4'hF, d); chk("R1 queue empty", d, 32'h8000_0000);

        for (int i = 0; i < NV; i++) begin
            logic [74:0] v;
            string tag;
            v = VEC[i];
            tag = $sformatf("R%0d vector %0d", v[74:71], i);
            case (v[70:69])
                OP_W: wr(v[68:64], 4'hF, v[63:32]);
                OP_P: push(v[39:32]);
                default: begin
                    rd(v[68:64], 4'hF, d);
                    chk(tag, d, v[31:0]);
                end
            endcase
        end

        // R4 transmit pulse
        wr(5'h00, 4'hF, 32'hDEAD_BEA5);
        chk("R4 tx_valid high", 32'(tx_valid), 32'h1);
        chk("R4 tx_data", 32'(tx_data), 32'hA5);
        @(negedge clk);
        chk("R4 tx_valid one cycle", 32'(tx_valid), 32'h0);

        // R9 interrupt mapping
        chk("R9 both enabled tx pending", 32'(irq), 32'h1);
        wr(5'h10, 4'hF, 32'h0); chk("R9 none enabled", 32'(irq), 32'h0);
        wr(5'h10, 4'hF, 32'h1); chk("R9 tx enabled", 32'(irq), 32'h1);
        wr(5'h08, 4'hF, 32'h0); chk("R9 tx wm cleared", 32'(irq), 32'h0);
        wr(5'h10, 4'hF, 32'h2); chk("R9 rx enabled, empty", 32'(irq), 32'h0);
        wr(5'h0C, 4'hF, 32'h0);
        push(8'h5A);            chk("R9 rx pending", 32'(irq), 32'h1);
        rd(5'h04, 4'hF, d);     chk("R2 single byte", d, 32'h5A);
        chk("R9 rx drained", 32'(irq), 32'h0);

        // R8 fill to capacity and overflow
        for (int i = 0; i < 10; i++) begin
            chk($sformatf("R8 ready before byte %0d", i), 32'(rx_ready), (i < 8) ? 32'h1 : 32'h0);
            push(8'(8'h30 + i));
        end
        chk("R8 ready low when full", 32'(rx_ready), 32'h0);
        for (int i = 0; i < 8; i++) begin
            rd(5'h04, 4'hF, d);
            chk($sformatf("R8 drain byte %0d", i), d, 32'(8'h30 + i));
        end
        rd(5'h04, 4'hF, d); chk("R8 extras discarded", d, 32'h8000_0000);
        chk("R8 ready back", 32'(rx_ready), 32'h1);

        // R10 narrow accesses
        push(8'h77);
        wr(5'h10, 4'h3, 32'h0);
        rd(5'h10, 4'hF, d); chk("R10 narrow write ignored", d, 32'h2);
        rd(5'h04, 4'h1, d); chk("R10 narrow read is zero", d, 32'h0);
        rd(5'h04, 4'hF, d); chk("R10 narrow read did not pop", d, 32'h77);
        rd(5'h04, 4'hF, d); chk("R3 empty again", d, 32'h8000_0000);
        rd(5'h10, 4'hF, d); chk("R3 empty read kept enable", d, 32'h2);

        finish_run();
    end
endmodule